// File: doc/BRIEF.md
# Vector predicate mask resolver

This block turns a small set of packed predicate configuration words into per-register predicate masks for a vector datapath. Software writes up to sixteen 15-bit configuration words through a register-style write port. Each write starts a rebuild of two lookup tables, one for integer registers and one for floating-point registers. Each table has 32 slots and is indexed by a 5-bit register key. While the rebuild runs, `busy` is high and lookups are held off.

A lookup presents a register key, an integer/floating-point select and the register-active flag taken from the register table. The block drives the index of the predicate register to an external integer register file read port and receives that register's value in the same cycle. One cycle later it returns a 64-bit mask and a zeroing flag. The value is passed through or complemented according to the slot's invert flag. Predication applies only when both the register and its predicate slot are active; in every other case the mask is all ones and the zeroing flag is 0.

Top module: `pred_mask_resolver`

## Requirements
- R1: A configuration word is decoded as follows: key in bits 4:0, zeroing flag in bit 5 (1 = zeroing, 0 = skipping), invert flag in bit 6, table type in bit 7 (1 = integer table, 0 = floating-point table), predicate register index in bits 13:8, active flag in bit 14.
- R2: Writing word i replaces that word and clears every word with an index above i.
- R3: A rebuild first empties both tables. It then scans the words from index 0 upward and stops at the first word that is entirely zero; later words have no effect.
- R4: Each scanned word loads the slot chosen by its type and key with its index, zeroing, invert and active flags. A later word with the same type and key overwrites an earlier one.
- R5: When the lookup's register-active flag is 0, the mask is all ones and the zeroing flag is 0.
- R6: When the register is active but its slot is inactive (including an empty slot), the mask is all ones and the zeroing flag is 0.
- R7: When predication applies, `rf_idx` carries the slot's index, the mask equals `rf_data`, and the zeroing flag equals the slot's zeroing flag.
- R8: When predication applies and the slot's invert flag is set, the mask is the bitwise complement of `rf_data`.
- R9: `busy` rises in the cycle after a write and stays high for 1 + min(k+1, 16) cycles, where k is the number of leading non-zero words. While `busy` is high, `lk_ready` is 0 and lookups are ignored.
- R10: `rsp_valid` is high exactly in the cycle after an accepted lookup.
- R11: Reading the configuration words always returns zero.
- R12: After reset, `busy` and `rsp_valid` are 0, `lk_ready` is 1 and both tables are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Write strobe for a configuration word |
| cfg_addr | input | 4 | Configuration word index |
| cfg_wdata | input | 15 | Configuration word value |
| cfg_rdata | output | 15 | Read data, always zero |
| busy | output | 1 | Table rebuild in progress |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_key | input | 5 | Register key of the lookup |
| lk_is_int | input | 1 | 1 selects the integer table, 0 the floating-point table |
| lk_reg_active | input | 1 | Register-active flag from the register table |
| rf_idx | output | 6 | Predicate register index to the register file read port |
| rf_data | input | 64 | Value of the register named by `rf_idx` |
| rsp_valid | output | 1 | Result valid |
| rsp_mask | output | 64 | Predicate mask |
| rsp_zero | output | 1 | Zeroing flag (1 = zeroing, 0 = skipping) |

## Verification
A wrong slot in either table appears at the ports on the first lookup of that type and key with the register active. It shows as a wrong mask, a wrong complement or a wrong zeroing flag, one cycle after the request. The sweeps therefore cover every key of both tables with the register active and inactive after each configuration change. A wrong scan pointer or stop condition shows first as a wrong `busy` length after the write, and then as slots that are filled or left empty where they should not be.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
    localparam int KEY_W  = 5;
    localparam int IDX_W  = 6;
    localparam int ENT_W  = KEY_W + 3 + IDX_W + 1;
    localparam int SLOTS  = 2 ** KEY_W;

    // Bit layout is fixed: active[14] idx[13:8] type[7] inv[6] zero[5] key[4:0]
    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] pidx;
        logic             is_int;
        logic             inv;
        logic             zero;
        logic [KEY_W-1:0] key;
    } pent_t;

    typedef struct packed {
        logic             active;
        logic             zero;
        logic             inv;
        logic [IDX_W-1:0] pidx;
    } slot_t;

    typedef enum logic [1:0] {
        B_IDLE  = 2'd0,
        B_CLEAR = 2'd1,
        B_SCAN  = 2'd2
    } bstate_t;
endpackage

// File: rtl/pmr_entry_store.sv
module pmr_entry_store
    import pmr_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int AW = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  pent_t             wr_data,
    output pent_t [N_ENT-1:0] ent
);
    typedef struct packed {
        pent_t [N_ENT-1:0] ent;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int j = 0; j < N_ENT; j++) begin
                if (AW'(j) == wr_addr) begin
                    st_d.ent[j] = wr_data;
                end else if (AW'(j) > wr_addr) begin
                    st_d.ent[j] = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ent = st_q.ent;

    for (genvar g = 1; g < N_ENT; g++) begin : g_clr_chk
        assert_write_clears_higher_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr < AW'(g)) |=> (ent[g] == '0));
    end
endmodule

// File: rtl/pmr_table_build.sv
module pmr_table_build
    import pmr_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int AW = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  pent_t [N_ENT-1:0] ent,
    output logic              busy,
    output slot_t [SLOTS-1:0] int_tbl,
    output slot_t [SLOTS-1:0] fp_tbl
);
    typedef struct packed {
        bstate_t           st;
        logic [AW-1:0]     ptr;
        slot_t [SLOTS-1:0] itbl;
        slot_t [SLOTS-1:0] ftbl;
    } st_t;

    st_t   st_d, st_q;
    pent_t cur;
    logic  cur_zero;
    slot_t cur_slot;

    always_comb begin
        st_d     = st_q;
        cur      = ent[st_q.ptr];
        cur_zero = (cur == '0);
        cur_slot = '{active: cur.active, zero: cur.zero, inv: cur.inv, pidx: cur.pidx};
        unique case (st_q.st)
            B_CLEAR: begin
                st_d.itbl = '0;
                st_d.ftbl = '0;
                st_d.ptr  = '0;
                st_d.st   = B_SCAN;
            end
            B_SCAN: begin
                if (cur_zero) begin
                    st_d.st = B_IDLE;
                end else begin
                    if (cur.is_int) st_d.itbl[cur.key] = cur_slot;
                    else            st_d.ftbl[cur.key] = cur_slot;
                    if (st_q.ptr == AW'(N_ENT - 1)) st_d.st = B_IDLE;
                    else                            st_d.ptr = st_q.ptr + 1'b1;
                end
            end
            default: ;
        endcase
        if (start) begin
            st_d.st = B_CLEAR;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{st: B_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign busy    = (st_q.st != B_IDLE);
    assign int_tbl = st_q.itbl;
    assign fp_tbl  = st_q.ftbl;

    assert_scan_stops_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == B_SCAN && cur_zero && !start) |=> !busy);
    assert_scan_ends_at_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == B_SCAN && st_q.ptr == AW'(N_ENT - 1) && !start) |=> !busy);
    assert_clear_then_scan_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == B_CLEAR && !start) |=> (st_q.st == B_SCAN && st_q.ptr == '0));
endmodule

// File: rtl/pmr_lookup.sv
module pmr_lookup
    import pmr_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [KEY_W-1:0]  key,
    input  logic              is_int,
    input  logic              reg_active,
    input  slot_t [SLOTS-1:0] int_tbl,
    input  slot_t [SLOTS-1:0] fp_tbl,
    output logic [IDX_W-1:0]  rf_idx,
    input  logic [DATA_W-1:0] rf_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_mask,
    output logic              rsp_zero
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] mask;
        logic              zero;
    } st_t;

    st_t   st_d, st_q;
    slot_t slot;
    logic  applies;

    always_comb begin
        st_d       = st_q;
        slot       = is_int ? int_tbl[key] : fp_tbl[key];
        applies    = reg_active && slot.active;
        st_d.valid = req;
        if (req) begin
            if (applies) begin
                st_d.mask = slot.inv ? ~rf_data : rf_data;
                st_d.zero = slot.zero;
            end else begin
                st_d.mask = '1;
                st_d.zero = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rf_idx    = slot.pidx;
    assign rsp_valid = st_q.valid;
    assign rsp_mask  = st_q.mask;
    assign rsp_zero  = st_q.zero;

    assert_inactive_reg_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !reg_active) |=> (rsp_mask == '1 && !rsp_zero));
    assert_inactive_slot_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !slot.active) |=> (rsp_mask == '1 && !rsp_zero));
    assert_invert_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && reg_active && slot.active && slot.inv) |=> (rsp_mask == ~$past(rf_data)));
    assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_valid);
    assert_no_rsp_without_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rsp_valid);
endmodule

// File: rtl/pred_mask_resolver.sv
module pred_mask_resolver
    import pmr_pkg::*;
#(
    parameter int N_ENT  = 16,
    parameter int DATA_W = 64,
    localparam int AW = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [ENT_W-1:0]  cfg_wdata,
    output logic [ENT_W-1:0]  cfg_rdata,
    output logic              busy,
    input  logic              lk_valid,
    output logic              lk_ready,
    input  logic [KEY_W-1:0]  lk_key,
    input  logic              lk_is_int,
    input  logic              lk_reg_active,
    output logic [IDX_W-1:0]  rf_idx,
    input  logic [DATA_W-1:0] rf_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_mask,
    output logic              rsp_zero
);
    pent_t [N_ENT-1:0] ent;
    slot_t [SLOTS-1:0] int_tbl;
    slot_t [SLOTS-1:0] fp_tbl;
    logic              accept;

    pmr_entry_store #(.N_ENT(N_ENT)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_addr),
        .wr_data (pent_t'(cfg_wdata)),
        .ent     (ent)
    );

    pmr_table_build #(.N_ENT(N_ENT)) build_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (cfg_wr_en),
        .ent     (ent),
        .busy    (busy),
        .int_tbl (int_tbl),
        .fp_tbl  (fp_tbl)
    );

    assign lk_ready  = !busy;
    assign accept    = lk_valid && !busy;
    assign cfg_rdata = '0;

    pmr_lookup #(.DATA_W(DATA_W)) lookup_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (accept),
        .key        (lk_key),
        .is_int     (lk_is_int),
        .reg_active (lk_reg_active),
        .int_tbl    (int_tbl),
        .fp_tbl     (fp_tbl),
        .rf_idx     (rf_idx),
        .rf_data    (rf_data),
        .rsp_valid  (rsp_valid),
        .rsp_mask   (rsp_mask),
        .rsp_zero   (rsp_zero)
    );

    assert_busy_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> busy);
    assert_busy_blocks_lookup_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && busy) |=> !rsp_valid);
endmodule

// File: tb/pred_mask_resolver_tb.sv
module pred_mask_resolver_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [14:0] cfg_wdata = '0;
    logic [14:0] cfg_rdata;
    logic        busy;
    logic        lk_valid = 1'b0;
    logic        lk_ready;
    logic [4:0]  lk_key = '0;
    logic        lk_is_int = 1'b0;
    logic        lk_reg_active = 1'b0;
    logic [5:0]  rf_idx;
    logic [63:0] rf_data;
    logic        rsp_valid;
    logic [63:0] rsp_mask;
    logic        rsp_zero;

    int checks = 0;
    int errors = 0;
    logic [14:0] m_ent [16];
    bit done = 0;

    always #5 clk = ~clk;

    function automatic logic [63:0] pat(input logic [5:0] i);
        return {26'h2A5A5A5, i, 26'h1F0F0F0, i};
    endfunction

    assign rf_data = pat(rf_idx);

    pred_mask_resolver dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_key(lk_key),
        .lk_is_int(lk_is_int), .lk_reg_active(lk_reg_active), .rf_idx(rf_idx),
        .rf_data(rf_data), .rsp_valid(rsp_valid), .rsp_mask(rsp_mask), .rsp_zero(rsp_zero)
    );

    function automatic logic [14:0] mk(input int key, input bit zr, input bit inv,
                                       input bit isint, input int idx, input bit act);
        return {act, 6'(idx), isint, inv, zr, 5'(key)};
    endfunction

    task automatic chk(input string req, input bit ok, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    function automatic int lead_k();
        int k = 0;
        for (int i = 0; i < 16; i++) begin
            if (m_ent[i] == '0) break;
            k++;
        end
        return k;
    endfunction

    task automatic wr_entry(input int a, input logic [14:0] v);
        int n = 0;
        int k;
        int exp;
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = 4'(a); cfg_wdata = v;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        m_ent[a] = v;
        for (int j = a + 1; j < 16; j++) m_ent[j] = '0;
        k = lead_k();
        exp = 1 + ((k + 1 < 16) ? k + 1 : 16);
        while (busy && n < 100) begin
            if (lk_ready) n = 1000;
            n++;
            @(negedge clk);
        end
        chk("R9 busy length", n == exp, 64'(n), 64'(exp));
    endtask

    task automatic do_lookup(input int key, input bit isint, input bit ra);
        bit act, zr, inv;
        int idx;
        logic [63:0] emask;
        bit ezero;
        string tag;
        act = 0; zr = 0; inv = 0; idx = 0;
        for (int i = 0; i < 16; i++) begin
            if (m_ent[i] == '0) break;
            if (int'(m_ent[i][4:0]) == key && m_ent[i][7] == isint) begin
                act = m_ent[i][14]; zr = m_ent[i][5]; inv = m_ent[i][6]; idx = int'(m_ent[i][13:8]);
            end
        end
        if (!ra) begin
            tag = "R5"; emask = '1; ezero = 0;
        end else if (!act) begin
            tag = "R6"; emask = '1; ezero = 0;
        end else begin
            tag = inv ? "R8" : "R7";
            emask = inv ? ~pat(6'(idx)) : pat(6'(idx));
            ezero = zr;
        end
        @(negedge clk);
        lk_valid = 1'b1; lk_key = 5'(key); lk_is_int = isint; lk_reg_active = ra;
        @(negedge clk);
        lk_valid = 1'b0;
        chk({tag, " R10 R1 R4 mask"}, rsp_valid && rsp_mask == emask, rsp_mask, emask);
        chk({tag, " zero flag"}, rsp_zero == ezero, 64'(rsp_zero), 64'(ezero));
    endtask

    task automatic sweep();
        for (int t = 0; t < 2; t++)
            for (int key = 0; key < 32; key++)
                for (int ra = 0; ra < 2; ra++)
                    do_lookup(key, t[0], ra[0]);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_ent[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state, R11 read data
        chk("R12 busy", !busy && lk_ready, 64'(busy), 64'(0));
        chk("R12 rsp_valid", !rsp_valid, 64'(rsp_valid), 64'(0));
        chk("R11 rdata", cfg_rdata == '0, 64'(cfg_rdata), 64'(0));
        sweep();

        // R1 R4: mixed types, flags, duplicate key overwrite
        wr_entry(0, mk(3, 1, 0, 1, 10, 1));
        wr_entry(1, mk(3, 0, 1, 0, 20, 1));
        wr_entry(2, mk(7, 0, 0, 1, 33, 0));
        wr_entry(3, mk(31, 1, 1, 1, 63, 1));
        wr_entry(4, mk(0, 0, 0, 0, 1, 1));
        wr_entry(5, mk(3, 0, 1, 1, 5, 1));
        sweep();

        // R2: rewriting word 2 clears words 3..5
        wr_entry(2, mk(9, 1, 0, 0, 2, 1));
        chk("R11 rdata after writes", cfg_rdata == '0, 64'(cfg_rdata), 64'(0));
        sweep();

        // R3: zero word at 1 stops the scan before word 2
        wr_entry(1, 15'h0);
        wr_entry(2, mk(12, 0, 0, 1, 7, 1));
        sweep();

        // R9 full table: all sixteen words non-zero
        for (int i = 0; i < 16; i++)
            wr_entry(i, mk((i * 5) % 32, i[0], i[1], i[2], i * 3 + 1, (i % 5) != 4));
        sweep();

        // R9: lookup during a rebuild is ignored
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = 4'd15; cfg_wdata = mk(30, 1, 1, 0, 40, 1);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        m_ent[15] = mk(30, 1, 1, 0, 40, 1);
        chk("R9 ready low while busy", busy && !lk_ready, 64'(lk_ready), 64'(0));
        lk_valid = 1'b1; lk_key = 5'd30; lk_is_int = 1'b0; lk_reg_active = 1'b1;
        @(negedge clk);
        lk_valid = 1'b0;
        chk("R9 lookup ignored while busy", !rsp_valid, 64'(rsp_valid), 64'(0));
        while (busy) @(negedge clk);
        do_lookup(30, 1'b0, 1'b1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule